// File: doc/BRIEF.md
# Hardware Debug Breakpoint Match Unit

This unit sits beside a processor core's fetch and load/store paths and watches for four programmable debug conditions. Software programs four slot address registers and one control word that picks, for each slot, what kind of event it watches, how wide a byte range it covers, and whether it may raise an exception. On every cycle the unit compares the fetch program counter and any data access against all four slots.

The status word keeps a record of which slots matched. The record includes slots that are disabled, but it is written into the status register only when an enabled slot matched or when a single-step event forces the write. A debug exception request is raised one cycle after the edge that evaluates the condition. A single-step event always raises that request, and it also sets a dedicated step flag in the status word. Software reads and writes all registers through a small indexed port.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset the control register reads 0x0000_0400, and the status register, all four slot addresses and `dbg_req` read zero.
- R2: Register index map: 0 to 3 are the slot addresses, 6 is status and 7 is control. Writes to indices 4 and 5 are ignored and those indices read zero. Control bit 10 always reads 1, and every other written control bit is kept as written.
- R3: Slot i is enabled when control bit 2i or control bit 2i+1 is set. Either bit alone is enough.
- R4: The kind field of slot i is control bits [17+4i:16+4i]. Kind 00 (execute) matches when `fetch_valid` is high and the slot address exactly equals `fetch_pc`. The length field is ignored for this kind.
- R5: A slot of kind 10 (port access) never matches.
- R6: The length field of slot i is control bits [19+4i:18+4i], with 00=1, 01=2, 11=4 and 10=8 bytes. The watched range is the slot address aligned down to that length. A data access covers 2^`dacc_size` bytes starting at `dacc_addr`, and it matches when that span overlaps the watched range.
- R7: Kind 01 matches only when `dacc_write` is 1. Kind 11 matches both reads and writes. Both kinds need `dacc_valid`.
- R8: When at least one enabled slot matches, the next status value has bits [3:0] equal to the match vector of all four slots, enabled or not, and keeps all other bits. `dbg_req` is 1 in the cycle after that edge.
- R9: When no enabled slot matches and there is no step event, status is unchanged and `dbg_req` is 0 in the next cycle.
- R10: A step event commits status with bits [3:0] equal to the match vector and bit 14 set, and it raises `dbg_req` in the next cycle.
- R11: A software write to status wins over a same-cycle commit. Matching in a cycle uses the register values from before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | XLEN | Current instruction pointer |
| dacc_valid | input | 1 | Data access present this cycle |
| dacc_addr | input | XLEN | Data access start address |
| dacc_size | input | 2 | Log2 of the access size in bytes |
| dacc_write | input | 1 | 1 = write, 0 = read |
| step_evt | input | 1 | Single-step event |
| reg_we | input | 1 | Register write strobe |
| reg_widx | input | 3 | Register index for the write |
| reg_wdata | input | XLEN | Write data |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | XLEN | Read data for `rd_idx` |
| dbg_req | output | 1 | Debug exception request, registered |

## Verification
A corrupted slot comparator or a corrupted field decode shows up as wrong bits in status [3:0] or a wrong `dbg_req`. Both appear in the first cycle after the access that should or should not have matched. A status commit that fires when it should not, or fails to fire when it should, becomes visible one cycle later as a status readback that differs from the expected value, and the difference persists until the next commit or write. Because random traffic often targets slot addresses and their byte neighbours, the length and kind decodes are exercised at their range edges.

// File: rtl/dbgm_pkg.sv
// Package: shared constants and the slot kind encoding for the debug match unit.
// Assumes the register width is at least 32 bits so that every control field fits.
package dbgm_pkg;
    localparam int NSLOT      = 4;
    localparam int IDX_STATUS = 6;
    localparam int IDX_CTRL   = 7;
    localparam int CTRL_ONE   = 10;
    localparam int STEP_BIT   = 14;
    localparam int KIND_LSB   = 16;
    localparam int LEN_LSB    = 18;
    localparam int FIELD_STEP = 4;

    typedef enum logic [1:0] {
        BK_EXEC   = 2'b00,
        BK_WRITE  = 2'b01,
        BK_PORT   = 2'b10,
        BK_ACCESS = 2'b11
    } bk_kind_e;

    // Map the length encoding to log2 of the byte count.
    function automatic logic [1:0] len_log2(input logic [1:0] enc);
        case (enc)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/dbgm_regs.sv
// Module: register storage for slot addresses, control and status.
// Assumes that a software write to status takes priority over a commit from
// the match logic in the same cycle. Control bit 10 is forced to one.
module dbgm_regs
    import dbgm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_idx,
    input  logic [XLEN-1:0]            wr_data,
    input  logic                       commit,
    input  logic [XLEN-1:0]            commit_val,
    output logic [NSLOT-1:0][XLEN-1:0] addr_q,
    output logic [XLEN-1:0]            ctrl_q,
    output logic [XLEN-1:0]            stat_q
);
    localparam logic [XLEN-1:0] CTRL_RST = XLEN'(1) << CTRL_ONE;

    // Slot address and control registers, written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            ctrl_q <= CTRL_RST;
        end else if (wr_en) begin
            if (!wr_idx[2]) begin
                addr_q[wr_idx[1:0]] <= wr_data;
            end else if (wr_idx == 3'(IDX_CTRL)) begin
                ctrl_q <= wr_data | CTRL_RST;
            end
        end
    end

    // Status register: a software write wins, otherwise take a match commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (wr_en && wr_idx == 3'(IDX_STATUS)) begin
            stat_q <= wr_data;
        end else if (commit) begin
            stat_q <= commit_val;
        end
    end

    p_ctrl_fixed_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 3'(IDX_CTRL)) |=> ctrl_q[CTRL_ONE]);

    p_sw_status_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 3'(IDX_STATUS)) |=> stat_q == $past(wr_data));
endmodule

// File: rtl/dbgm_slot_cmp.sv
// Module: compares one breakpoint slot with the fetch PC and the data access.
// Assumes the data access span is 1 to 8 bytes and that address arithmetic
// does not wrap (it is computed one bit wider than the address).
module dbgm_slot_cmp
    import dbgm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] slot_addr,
    input  logic [1:0]      kind,
    input  logic [1:0]      len_enc,
    input  logic            fetch_valid,
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            dacc_valid,
    input  logic [XLEN-1:0] dacc_addr,
    input  logic [1:0]      dacc_size,
    input  logic            dacc_write,
    output logic            hit
);
    localparam int W = XLEN + 1;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] mask_lo, base, slot_end, a_lo, a_hi;
    logic         overlap;

    // Watched range and access span, then the overlap test.
    always_comb begin
        mask_lo  = (ONE << len_log2(len_enc)) - ONE;
        base     = {1'b0, slot_addr} & ~mask_lo;
        slot_end = base | mask_lo;
        a_lo     = {1'b0, dacc_addr};
        a_hi     = a_lo + (ONE << dacc_size) - ONE;
        overlap  = (a_lo <= slot_end) && (a_hi >= base);
    end

    // Select the match rule from the slot kind.
    always_comb begin
        case (bk_kind_e'(kind))
            BK_EXEC:   hit = fetch_valid && (slot_addr == fetch_pc);
            BK_WRITE:  hit = dacc_valid && dacc_write && overlap;
            BK_ACCESS: hit = dacc_valid && overlap;
            default:   hit = 1'b0;
        endcase
    end

    p_port_never_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b10) |-> !hit);

    p_write_kind_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == 2'b01) |-> (dacc_valid && dacc_write));

    p_exec_kind_needs_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == 2'b00) |-> fetch_valid);
endmodule

// File: rtl/dbgm_eval.sv
// Module: combines slot matches with the enables and builds the status update.
// Assumes the match vector covers all slots whether or not they are enabled.
module dbgm_eval
    import dbgm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  ctrl,
    input  logic [XLEN-1:0]  stat,
    input  logic [NSLOT-1:0] hits,
    input  logic             step,
    output logic             en_hit,
    output logic             commit,
    output logic [XLEN-1:0]  commit_val
);
    logic [NSLOT-1:0] enabled;

    // Fold the local and global enable bits of each slot together.
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            enabled[i] = ctrl[2*i] | ctrl[2*i+1];
        end
    end

    // Decide the commit and form the new status word.
    always_comb begin
        en_hit     = |(hits & enabled);
        commit     = en_hit | step;
        commit_val = {stat[XLEN-1:NSLOT], hits};
        if (step) begin
            commit_val[STEP_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/dbg_match_unit.sv
// Module: top of the hardware debug breakpoint match unit.
// Holds four slots, control and status. It evaluates every cycle and registers
// the debug request. Assumes reads are combinational from the registers.
module dbg_match_unit
    import dbgm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            dacc_valid,
    input  logic [XLEN-1:0] dacc_addr,
    input  logic [1:0]      dacc_size,
    input  logic            dacc_write,
    input  logic            step_evt,
    input  logic            reg_we,
    input  logic [2:0]      reg_widx,
    input  logic [XLEN-1:0] reg_wdata,
    input  logic [2:0]      rd_idx,
    output logic [XLEN-1:0] rd_data,
    output logic            dbg_req
);
    logic [NSLOT-1:0][XLEN-1:0] addr_q;
    logic [XLEN-1:0]            ctrl_q, stat_q, commit_val;
    logic [NSLOT-1:0]           hits;
    logic                       en_hit, commit, req_q;

    dbgm_regs #(.XLEN(XLEN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .wr_idx     (reg_widx),
        .wr_data    (reg_wdata),
        .commit     (commit),
        .commit_val (commit_val),
        .addr_q     (addr_q),
        .ctrl_q     (ctrl_q),
        .stat_q     (stat_q)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        dbgm_slot_cmp #(.XLEN(XLEN)) u_cmp (
            .clk         (clk),
            .rst_n       (rst_n),
            .slot_addr   (addr_q[i]),
            .kind        (ctrl_q[KIND_LSB+FIELD_STEP*i +: 2]),
            .len_enc     (ctrl_q[LEN_LSB+FIELD_STEP*i +: 2]),
            .fetch_valid (fetch_valid),
            .fetch_pc    (fetch_pc),
            .dacc_valid  (dacc_valid),
            .dacc_addr   (dacc_addr),
            .dacc_size   (dacc_size),
            .dacc_write  (dacc_write),
            .hit         (hits[i])
        );
    end

    dbgm_eval #(.XLEN(XLEN)) u_eval (
        .ctrl       (ctrl_q),
        .stat       (stat_q),
        .hits       (hits),
        .step       (step_evt),
        .en_hit     (en_hit),
        .commit     (commit),
        .commit_val (commit_val)
    );

    // Register the debug exception request.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= en_hit | step_evt;
    end

    // Read multiplexer over the register index map.
    always_comb begin
        if (!rd_idx[2])                     rd_data = addr_q[rd_idx[1:0]];
        else if (rd_idx == 3'(IDX_STATUS))  rd_data = stat_q;
        else if (rd_idx == 3'(IDX_CTRL))    rd_data = ctrl_q;
        else                                rd_data = '0;
    end

    assign dbg_req = req_q;

    p_req_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hit && !(reg_we && reg_widx == 3'(IDX_STATUS))) |=>
            (dbg_req && stat_q[NSLOT-1:0] == $past(hits)));

    p_idle_holds_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_hit && !step_evt && !reg_we) |=> ($stable(stat_q) && !dbg_req));

    p_step_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt && !(reg_we && reg_widx == 3'(IDX_STATUS))) |=>
            (dbg_req && stat_q[STEP_BIT]));
endmodule

// File: tb/dbg_match_unit_bench.sv
module dbg_match_unit_bench;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_valid = 1'b0;
    logic [XLEN-1:0] fetch_pc = '0;
    logic            dacc_valid = 1'b0;
    logic [XLEN-1:0] dacc_addr = '0;
    logic [1:0]      dacc_size = '0;
    logic            dacc_write = 1'b0;
    logic            step_evt = 1'b0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_widx = '0;
    logic [XLEN-1:0] reg_wdata = '0;
    logic [2:0]      rd_idx = 3'd6;
    logic [XLEN-1:0] rd_data;
    logic            dbg_req;

    int unsigned n_tests = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    logic [XLEN-1:0] m_addr [4];
    logic [XLEN-1:0] m_ctrl, m_stat;
    logic            m_req;

    always #5 clk = ~clk;

    dbg_match_unit #(.XLEN(XLEN)) u_dbg_match_unit (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .dacc_valid(dacc_valid), .dacc_addr(dacc_addr), .dacc_size(dacc_size),
        .dacc_write(dacc_write), .step_evt(step_evt), .reg_we(reg_we),
        .reg_widx(reg_widx), .reg_wdata(reg_wdata), .rd_idx(rd_idx),
        .rd_data(rd_data), .dbg_req(dbg_req)
    );

    function automatic logic [XLEN-1:0] exp_read(input logic [2:0] idx);
        if (idx < 3'd4)  return m_addr[idx[1:0]];
        if (idx == 3'd6) return m_stat;
        if (idx == 3'd7) return m_ctrl;
        return '0;
    endfunction

    // Expected match of slot i from the requirement text (R4 to R7).
    function automatic bit exp_hit(input int i);
        logic [1:0] kind, len;
        longint unsigned span, base, last, lo, hi;
        kind = m_ctrl[16+4*i +: 2];
        len  = m_ctrl[18+4*i +: 2];
        case (len)
            2'b00: span = 1;
            2'b01: span = 2;
            2'b11: span = 4;
            default: span = 8;
        endcase
        base = longint'(m_addr[i]) & ~(span - 1);
        last = base + span - 1;
        lo   = longint'(dacc_addr);
        hi   = lo + (longint'(1) << dacc_size) - 1;
        case (kind)
            2'b00: return fetch_valid && (m_addr[i] == fetch_pc);
            2'b01: return dacc_valid && dacc_write && lo <= last && hi >= base;
            2'b11: return dacc_valid && lo <= last && hi >= base;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One clock with the inputs as set. Model update, then port checks.
    task automatic cycle(input string tag_in);
        logic [3:0] hv;
        bit         enh;
        string      tag;
        for (int i = 0; i < 4; i++) hv[i] = exp_hit(i);
        enh = 1'b0;
        for (int i = 0; i < 4; i++)
            if (hv[i] && (m_ctrl[2*i] || m_ctrl[2*i+1])) enh = 1'b1;
        tag = tag_in;
        if (tag == "") tag = step_evt ? "R10" : (enh ? "R8" : "R9");
        @(posedge clk);
        #1;
        m_req = enh | step_evt;
        if (enh || step_evt) begin
            m_stat[3:0] = hv;
            if (step_evt) m_stat[14] = 1'b1;
        end
        if (reg_we) begin
            if (reg_widx < 3'd4)       m_addr[reg_widx[1:0]] = reg_wdata;
            else if (reg_widx == 3'd6) m_stat = reg_wdata;
            else if (reg_widx == 3'd7) m_ctrl = reg_wdata | 32'h400;
        end
        check({tag, " req"}, {31'd0, dbg_req}, {31'd0, m_req});
        check({tag, " rd"}, rd_data, exp_read(rd_idx));
    endtask

    task automatic idle();
        fetch_valid = 1'b0; dacc_valid = 1'b0; step_evt = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [XLEN-1:0] d, input string tag);
        idle();
        reg_we = 1'b1; reg_widx = idx; reg_wdata = d; rd_idx = idx;
        cycle(tag);
        reg_we = 1'b0;
    endtask

    task automatic fetch(input logic [XLEN-1:0] pc, input string tag);
        idle(); fetch_valid = 1'b1; fetch_pc = pc; rd_idx = 3'd6;
        cycle(tag);
        idle();
    endtask

    task automatic access(input logic [XLEN-1:0] a, input logic [1:0] sz,
                          input logic w, input string tag);
        idle(); dacc_valid = 1'b1; dacc_addr = a; dacc_size = sz; dacc_write = w;
        rd_idx = 3'd6;
        cycle(tag);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_addr[i] = '0;
        m_ctrl = 32'h400; m_stat = '0; m_req = 1'b0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values over every index.
        for (int k = 0; k < 8; k++) begin
            rd_idx = 3'(k);
            #1 check("R1 reset rd", rd_data, exp_read(3'(k)));
        end
        check("R1 reset req", {31'd0, dbg_req}, 32'd0);

        // R2: fixed control bit, ignored indices.
        wr(3'd7, 32'h0, "R2");
        check("R2 ctrl fixed", rd_data, 32'h400);
        wr(3'd7, 32'hFFFF_FBFF, "R2");
        check("R2 ctrl all", rd_data, 32'hFFFF_FFFF);
        wr(3'd4, 32'hDEAD_BEEF, "R2");
        check("R2 idx4 reads zero", rd_data, 32'h0);
        rd_idx = 3'd5; #1 check("R2 idx5 reads zero", rd_data, 32'h0);
        wr(3'd7, 32'h0, "R2");

        // R4 and R3: execute slot 0.
        wr(3'd0, 32'h1000, "R4");
        wr(3'd7, 32'h1, "R3");
        fetch(32'h1000, "R4 exec hit");
        check("R4 status bit0", m_stat & 32'hF, 32'h1);
        fetch(32'h1001, "R4 exec off by one");
        wr(3'd6, 32'h0, "R2");
        wr(3'd7, 32'h0, "R3");
        fetch(32'h1000, "R3 disabled no req");
        // R10: step records the disabled match and the step flag.
        idle(); fetch_valid = 1'b1; fetch_pc = 32'h1000; step_evt = 1'b1; rd_idx = 3'd6;
        cycle("R10 step");
        check("R10 status", rd_data, 32'h4001);
        idle();
        wr(3'd6, 32'h0, "R2");
        wr(3'd7, 32'h2, "R3");
        fetch(32'h1000, "R3 global enable");

        // R5: port kind on slot 1.
        wr(3'd1, 32'h2000, "R5");
        wr(3'd7, (32'h2 << 20) | 32'h4, "R5");
        access(32'h2000, 2'd0, 1'b1, "R5 port write");
        access(32'h2000, 2'd2, 1'b0, "R5 port read");

        // R6 and R7: write kind, 4-byte range on slot 2.
        wr(3'd2, 32'h3002, "R6");
        wr(3'd7, (32'h1 << 24) | (32'h3 << 26) | 32'h20, "R6");
        access(32'h3003, 2'd0, 1'b1, "R6 range top");
        access(32'h3004, 2'd0, 1'b1, "R6 past range");
        access(32'h3000, 2'd0, 1'b0, "R7 read on write kind");
        access(32'h2FFE, 2'd2, 1'b1, "R6 span overlap");
        access(32'h2FFC, 2'd2, 1'b1, "R6 span below");

        // R7: access kind, 8-byte range on slot 3.
        wr(3'd3, 32'h4005, "R7");
        wr(3'd7, (32'h3 << 28) | (32'h2 << 30) | 32'h40, "R7");
        access(32'h4007, 2'd0, 1'b0, "R7 read on access kind");
        access(32'h4008, 2'd0, 1'b1, "R6 past 8-byte range");

        // R11: software status write beats a same-cycle commit.
        idle(); dacc_valid = 1'b1; dacc_addr = 32'h4000; dacc_size = 2'd0; dacc_write = 1'b1;
        reg_we = 1'b1; reg_widx = 3'd6; reg_wdata = 32'hABCD_0000; rd_idx = 3'd6;
        cycle("R11");
        check("R11 status", rd_data, 32'hABCD_0000);
        idle();

        // Random traffic.
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            idle();
            r = $urandom_range(0, 99);
            if (r < 6) begin
                reg_we = 1'b1;
                reg_widx = 3'($urandom_range(0, 7));
                reg_wdata = $urandom();
                if (reg_widx < 3'd4) reg_wdata = reg_wdata & 32'h0000_FFFF;
            end
            fetch_valid = $urandom_range(0, 1) == 1;
            fetch_pc = ($urandom_range(0, 1) == 1) ? m_addr[$urandom_range(0, 3)]
                                                  : ($urandom() & 32'hFFFF);
            dacc_valid = $urandom_range(0, 1) == 1;
            dacc_addr = m_addr[$urandom_range(0, 3)] + 32'($urandom_range(0, 14)) - 32'd7;
            dacc_size = 2'($urandom_range(0, 3));
            dacc_write = $urandom_range(0, 1) == 1;
            step_evt = $urandom_range(0, 29) == 0;
            rd_idx = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'd6;
            cycle("");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule